// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs. A host sees four 32-bit registers on a simple write-strobe bus with a combinational read path: a configuration/status word, a command word, a data word and a register-address word. The block divides the system clock to make the management clock MDC, shifts out management frames on the MDIO line, and captures the PHY's reply. Frames can use either the short-address framing (5-bit PHY, 5-bit register) or the extended-address framing (5-bit port, 5-bit device, 16-bit register address sent in a separate address frame).

Each transaction starts as a side effect of a register write. In extended mode, writing the address word sends an address frame. Writing the data word sends a write frame. Writing the command word with its read strobe set sends a read frame. A busy flag stays high for the whole frame, and the host polls it. During a read the master releases MDIO for the turnaround and data bits. If no PHY pulls the line low in the second turnaround bit, the block reports a read error and stores all ones as the read result.

Top module: `mdio_host_ctrl`

## Requirements
- R1: Registers decode at byte offsets 0x30 (config/status), 0x34 (command), 0x38 (data) and 0x3C (address). Every other offset reads 0. After reset all four registers read 0, MDC is low and MDIO is not driven.
- R2: Config/status layout: bit 0 busy (read-only), bit 1 read error (read-only), bit 6 extended framing when 1 and short framing when 0, bits 15:8 the divider value. Writable fields read back as written.
- R3: Command layout: bits 4:0 device/register address, bits 9:5 port/PHY address, bit 10 preamble suppress, bit 11 scan enable (stored only), bit 14 post-increment read. Bit 15 is the read strobe and always reads back 0.
- R4: MDC is low while idle. During a frame each MDC half period lasts exactly divider+1 system clocks.
- R5: Driven frame bits, as sampled on the rising edge of MDC, MSB first: 32 ones unless preamble is suppressed; start 01 (short) or 00 (extended); opcode; 5-bit port; 5-bit device; turnaround 10; 16 data bits. Short opcodes: read 10, write 01. Extended opcodes: address 00, write 01, read 11, post-increment read 10.
- R6: Busy reads 1 in the cycle after the launching write and stays 1 for exactly bits × 2 × (divider+1) cycles, where bits is 64 with preamble and 32 without. Data register bit 31 mirrors busy.
- R7: In extended mode a write to the address register stores the low 16 bits and launches an address frame carrying them. In short mode the same write only stores the value.
- R8: A write to the data register stores its low 16 bits and launches a write frame carrying them.
- R9: A command write with bit 15 set launches a read frame that uses the address fields of that same write. The master drives only the bits before the turnaround (the last 18 bits are released). At completion, data bits 15:0 hold the 16 bits received MSB first.
- R10: If MDIO is not low when the master samples the second turnaround bit, the read error bit is set and the data register becomes 0xFFFF. Launching a new read clears the read error bit.
- R11: While busy, every register write is ignored. No register changes and no extra frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench goes after the bit count and opcode for each frame kind. A design with a wrong preamble length or the wrong extended opcode shows a captured frame or busy duration that differs from the expected one. It also targets writes made while busy. A design that lets them through would overwrite the data word or start a second frame, and the stored result and captured bit count would show it. Reads are run against a present PHY model and an absent one, and an error flag left set from a failed read would show up on the next good read. The turnaround sample is hit exactly, so a design that sampled one bit late would take a data bit as turnaround.

// File: rtl/mdio_host_ctrl.sv
module mdio_host_ctrl #(
  parameter logic [7:0] DIV_RST = 8'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [5:0] OFF_CFG = 6'h30;
  localparam logic [5:0] OFF_CMD = 6'h34;
  localparam logic [5:0] OFF_DAT = 6'h38;
  localparam logic [5:0] OFF_ADR = 6'h3C;
  localparam int         PRE_LEN = 32;
  localparam int         FRM_LEN = 32;
  localparam int         SH_LEN  = PRE_LEN + FRM_LEN;

  logic        busy, rd_err, c45, mdc_q, rd_op, ta_ok;
  logic        pre_dis, scan_en, post_inc;
  logic [7:0]  div, cnt;
  logic [4:0]  dev, port;
  logic [15:0] data_q, addr_q, rx;
  logic [SH_LEN-1:0] sh;
  logic [6:0]  left;

  logic        unused_hi;
  assign unused_hi = ^bus_wdata[31:16];

  wire wr_ok  = bus_wr && !busy;
  wire go_rd  = wr_ok && bus_addr == OFF_CMD && bus_wdata[15];
  wire go_wr  = wr_ok && bus_addr == OFF_DAT;
  wire go_adr = wr_ok && bus_addr == OFF_ADR && c45;
  wire go     = go_rd || go_wr || go_adr;

  wire       f_pre  = go_rd ? bus_wdata[10] : pre_dis;
  wire       f_pinc = go_rd ? bus_wdata[14] : post_inc;
  wire [4:0] f_port = go_rd ? bus_wdata[9:5] : port;
  wire [4:0] f_dev  = go_rd ? bus_wdata[4:0] : dev;
  logic [1:0] f_op;
  always_comb begin
    if (go_rd)       f_op = c45 ? (f_pinc ? 2'b10 : 2'b11) : 2'b10;
    else if (go_adr) f_op = 2'b00;
    else             f_op = 2'b01;
  end
  wire [FRM_LEN-1:0] frame = {1'b0, !c45, f_op, f_port, f_dev, 2'b10, bus_wdata[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rd_err <= 1'b0; c45 <= 1'b0; mdc_q <= 1'b0; rd_op <= 1'b0;
      ta_ok <= 1'b0; pre_dis <= 1'b0; scan_en <= 1'b0; post_inc <= 1'b0;
      div <= DIV_RST; cnt <= '0; dev <= '0; port <= '0;
      data_q <= '0; addr_q <= '0; rx <= '0; sh <= '0; left <= '0;
    end else begin
      if (wr_ok) begin
        case (bus_addr)
          OFF_CFG: begin div <= bus_wdata[15:8]; c45 <= bus_wdata[6]; end
          OFF_CMD: begin
            dev <= bus_wdata[4:0]; port <= bus_wdata[9:5];
            pre_dis <= bus_wdata[10]; scan_en <= bus_wdata[11]; post_inc <= bus_wdata[14];
          end
          OFF_DAT: data_q <= bus_wdata[15:0];
          OFF_ADR: addr_q <= bus_wdata[15:0];
          default: ;
        endcase
      end
      if (go) begin
        busy  <= 1'b1;
        mdc_q <= 1'b0;
        cnt   <= '0;
        sh    <= f_pre ? {frame, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, frame};
        left  <= f_pre ? 7'(FRM_LEN) : 7'(SH_LEN);
        rd_op <= go_rd;
        ta_ok <= 1'b0;
        if (go_rd) rd_err <= 1'b0;
      end else if (busy) begin
        if (cnt == div) begin
          cnt   <= '0;
          mdc_q <= !mdc_q;
          if (!mdc_q) begin
            if (rd_op && left == 7'd17) ta_ok <= !mdio_i;
            if (rd_op && left <= 7'd16) rx <= {rx[14:0], mdio_i};
          end else if (left == 7'd1) begin
            busy <= 1'b0;
            if (rd_op) begin
              data_q <= ta_ok ? rx : 16'hFFFF;
              rd_err <= !ta_ok;
            end
          end else begin
            sh   <= {sh[SH_LEN-2:0], 1'b0};
            left <= left - 7'd1;
          end
        end else begin
          cnt <= cnt + 8'd1;
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh[SH_LEN-1];
  assign mdio_oe = busy && !(rd_op && left <= 7'd18);

  always_comb begin
    case (bus_addr)
      OFF_CFG: bus_rdata = {16'h0, div, 1'b0, c45, 4'h0, rd_err, busy};
      OFF_CMD: bus_rdata = {16'h0, 1'b0, post_inc, 2'b00, scan_en, pre_dis, port, dev};
      OFF_DAT: bus_rdata = {busy, 15'h0, data_q};
      OFF_ADR: bus_rdata = {16'h0, addr_q};
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/mdio_host_ctrl_chk.sv
module mdio_host_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic        rd_err,
  input logic [7:0]  div,
  input logic [15:0] data_q
);
  logic [8:0] run;
  logic       mdc_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; mdc_d <= 1'b0;
    end else begin
      mdc_d <= mdc;
      if (!busy)             run <= '0;
      else if (mdc != mdc_d) run <= 9'd1;
      else                   run <= run + 9'd1;
    end
  end

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc != $past(mdc)) |-> run == {1'b0, div} + 9'd1);

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h38 && !busy) |=> busy);

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(div));

  p_err_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> data_q == 16'hFFFF);
endmodule

bind mdio_host_ctrl mdio_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy), .rd_err(rd_err),
  .div(div), .data_q(data_q)
);

// File: tb/tb_mdio_host_ctrl.sv
module tb_mdio_host_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CFG = 6'h30, A_CMD = 6'h34, A_DAT = 6'h38, A_ADR = 6'h3C;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  mdio_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // PHY responder model
  int phy_idx = 0, phy_nb = 64;
  bit phy_rd = 0, phy_present = 1;
  logic [15:0] phy_data = '0;
  always @(negedge mdc) phy_idx++;
  always_comb begin
    if (mdio_oe) mdio_i = mdio_o;
    else if (phy_rd && phy_present && phy_idx == phy_nb - 17) mdio_i = 1'b0;
    else if (phy_rd && phy_present && phy_idx >= phy_nb - 16 && phy_idx < phy_nb)
      mdio_i = phy_data[15 - (phy_idx - (phy_nb - 16))];
    else mdio_i = 1'b1;
  end

  // captured master bits
  logic [63:0] cap = '0;
  int capn = 0;
  always @(posedge mdc) if (mdio_oe) begin cap = {cap[62:0], mdio_o}; capn++; end

  // per-clock MDC reference: every high phase lasts exactly div+1 clocks
  int exp_half = 1, run = 0;
  logic mdc_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mdc !== mdc_prev) begin
      if (!mdc) chk("R4 mdc half period", 64'(run), 64'(exp_half));
      run = 1;
    end else run++;
    mdc_prev = mdc;
  end

  time t_wr;
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); t_wr = $time;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] dv, input logic [15:0] dat);
    return {st, op, p, dv, 2'b10, dat};
  endfunction

  task automatic xfer(input logic [5:0] a, input logic [31:0] d, input int nb, input int dv,
      input bit is_rd, input logic [31:0] frame, input bit poke, input string req);
    logic [63:0] full, expd;
    time t_launch, t_end;
    int guard;
    cap = '0; capn = 0; phy_idx = 0; phy_nb = nb; phy_rd = is_rd; exp_half = dv + 1;
    wr(a, d);
    t_launch = t_wr;
    bus_addr = A_CFG; #1 chk({req, " R6 busy next cycle"}, 64'(bus_rdata[0]), 64'd1);
    bus_addr = A_DAT; #1 chk({req, " R6 data bit31 busy"}, 64'(bus_rdata[31]), 64'd1);
    if (poke) begin
      wr(A_DAT, 32'h0000_1234);
      wr(A_CMD, 32'h0000_8000 | (9 << 5) | 2);
      wr(A_CFG, 32'h0000_0740);
      wr(A_ADR, 32'h0000_4444);
    end
    guard = 0;
    do begin
      @(negedge clk); bus_addr = A_CFG; #1; guard++;
    end while (bus_rdata[0] && guard < 2000);
    t_end = $time - 1 - CLK_PERIOD/2;
    chk({req, " R6 busy length"}, 64'((t_end - t_launch) / CLK_PERIOD), 64'(nb * 2 * (dv + 1)));
    full = (nb == 64) ? {32'hFFFF_FFFF, frame} : {32'h0, frame};
    expd = is_rd ? (full >> 18) : full;
    chk({req, " R5 driven bit count"}, 64'(capn), 64'(is_rd ? nb - 18 : nb));
    chk({req, " R5 driven bits"}, cap, expd);
    phy_rd = 0;
  endtask

  logic [31:0] v;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and decode
    rd(A_CFG, v); chk("R1 cfg reset", 64'(v), 64'h0);
    rd(A_CMD, v); chk("R1 cmd reset", 64'(v), 64'h0);
    rd(A_DAT, v); chk("R1 data reset", 64'(v), 64'h0);
    rd(A_ADR, v); chk("R1 addr reset", 64'(v), 64'h0);
    chk("R1 idle pins", 64'({mdc, mdio_oe}), 64'h0);
    wr(A_CFG, 32'h0000_0140);
    rd(6'h00, v); chk("R1 unmapped reads zero", 64'(v), 64'h0);
    // R2 / R3 field readback
    rd(A_CFG, v); chk("R2 cfg readback", 64'(v), 64'h0140);
    wr(A_CFG, 32'h0000_0100);
    rd(A_CFG, v); chk("R2 cfg short mode", 64'(v), 64'h0100);
    wr(A_CMD, 32'h0000_4800 | (3 << 5) | 5'h11);
    rd(A_CMD, v); chk("R3 cmd readback", 64'(v), 64'(32'h4800 | (3 << 5) | 5'h11));
    wr(A_CMD, (3 << 5) | 5'h11);
    // R8 short write frame plus R11 writes while busy
    xfer(A_DAT, 32'hFFFF_A5C3, 64, 1, 0, mk(2'b01, 2'b01, 5'd3, 5'h11, 16'hA5C3), 1, "R8 short write");
    rd(A_DAT, v); chk("R11 data kept", 64'(v), 64'h0000_A5C3);
    rd(A_CMD, v); chk("R11 cmd kept", 64'(v), 64'((3 << 5) | 5'h11));
    rd(A_CFG, v); chk("R11 cfg kept", 64'(v), 64'h0100);
    rd(A_ADR, v); chk("R11 addr kept", 64'(v), 64'h0);
    rd(A_CFG, v); chk("R11 no extra frame", 64'({capn[7:0], v[0]}), 64'({8'd64, 1'b0}));
    // R9 short read, PHY present
    phy_present = 1; phy_data = 16'h5A0F;
    xfer(A_CMD, 32'h8000 | (3 << 5) | 5'h11, 64, 1, 1, mk(2'b01, 2'b10, 5'd3, 5'h11, 16'h8071), 0, "R9 short read");
    rd(A_DAT, v); chk("R9 read data", 64'(v), 64'h5A0F);
    rd(A_CFG, v); chk("R10 no error", 64'(v[1]), 64'h0);
    rd(A_CMD, v); chk("R3 strobe reads zero", 64'(v[15]), 64'h0);
    // R10 PHY absent
    phy_present = 0;
    xfer(A_CMD, 32'h8000 | (4 << 5) | 5'h02, 64, 1, 1, mk(2'b01, 2'b10, 5'd4, 5'h02, 16'h8082), 0, "R10 absent read");
    rd(A_DAT, v); chk("R10 data all ones", 64'(v), 64'hFFFF);
    rd(A_CFG, v); chk("R10 error set", 64'(v[1]), 64'h1);
    // R7 address write in short mode only stores
    wr(A_ADR, 32'h0000_0042);
    bus_addr = A_CFG; #1 chk("R7 short addr no busy", 64'(bus_rdata[0]), 64'h0);
    rd(A_ADR, v); chk("R7 addr stored", 64'(v), 64'h0042);
    // extended mode, divider 2, preamble suppressed
    wr(A_CFG, 32'h0000_0240);
    wr(A_CMD, (1 << 10) | (7 << 5) | 5'h1E);
    xfer(A_ADR, 32'h0000_8001, 32, 2, 0, mk(2'b00, 2'b00, 5'd7, 5'h1E, 16'h8001), 0, "R7 ext address");
    rd(A_ADR, v); chk("R7 ext addr stored", 64'(v), 64'h8001);
    xfer(A_DAT, 32'h0000_0BEE, 32, 2, 0, mk(2'b00, 2'b01, 5'd7, 5'h1E, 16'h0BEE), 0, "R8 ext write");
    phy_present = 1; phy_data = 16'h1357;
    xfer(A_CMD, 32'h8000 | (1 << 10) | (7 << 5) | 5'h1E, 32, 2, 1,
         mk(2'b00, 2'b11, 5'd7, 5'h1E, 16'h84FE), 0, "R9 ext read");
    rd(A_DAT, v); chk("R9 ext read data", 64'(v), 64'h1357);
    rd(A_CFG, v); chk("R10 error cleared by new read", 64'(v[1]), 64'h0);
    phy_data = 16'hC0DE;
    xfer(A_CMD, 32'hC000 | (7 << 5) | 5'h1E, 64, 2, 1,
         mk(2'b00, 2'b10, 5'd7, 5'h1E, 16'hC0FE), 0, "R9 post-increment read");
    rd(A_DAT, v); chk("R9 postinc data", 64'(v), 64'hC0DE);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule